// File: doc/BRIEF.md
# Queue Endpoint Control Register Block

This block is the host-visible register window of a queue-based storage endpoint. A host reaches it over a simple 32-bit read/write bus. It holds the constant capability and version words and the host-written configuration word. It also holds a status word whose bits come only from the device side, the admin queue size attributes, and the two 64-bit admin ring base addresses, each accessed as two 32-bit halves.

Above byte offset 0x1000 the block decodes an array of doorbells. Each queue pair owns two: a submission-tail doorbell and a completion-head doorbell. Their spacing is set by a stride parameter that is also reported in the capability word. An accepted doorbell write leaves the block as a one-cycle strobe that carries the queue number, the doorbell type and the written value.

Setting the configuration enable bit starts a fixed-length countdown, after which the ready status bit is set. Clearing the enable bit takes ready down after the same delay. While the block is enabled, the admin queue setup is frozen and can only be changed by disabling the block first or by reset.

Top module: `qctl_regfile`

## Requirements
- R1: After reset, the configuration, admin attribute and both base address registers read 0, the ready bit and `ctrl_ready` are 0, and no doorbell strobe is issued.
- R2: Offset 0x00 reads `{16'b0, QDEPTH-1}`, offset 0x04 reads `{28'b0, STRIDE}`, and offset 0x08 reads `VERSION`. Writes to these three offsets and to the status offset change nothing.
- R3: At offset 0x14 only bit 0 (enable) and bits 23:16 are stored; every other bit reads 0. Bit 0 drives `cfg_en`.
- R4: `ctrl_ready` (also status bit 0) rises exactly `RDY_DLY` clock edges after the edge that sets enable, and falls exactly `RDY_DLY` edges after the edge that clears it.
- R5: Status offset 0x1C reads `{29'b0, dev_busy, dev_fatal, ready}`.
- R6: Offset 0x24 stores the bits under mask 0x0FFF_0FFF. Offsets 0x28/0x2C hold the low/high halves of `asq_base`, and 0x30/0x34 hold the low/high halves of `acq_base`.
- R7: While enable is 1, writes to offsets 0x24 through 0x34 are ignored.
- R8: A doorbell sits at byte address 0x1000 + (2*qid + t) * (4 << STRIDE), where t=0 is the submission tail and t=1 is the completion head. A write there raises `db_strobe` for one cycle, starting at the write's clock edge, with `db_qid`=qid, `db_is_cq`=t and `db_value` equal to the written data.
- R9: No strobe is issued for a doorbell write that is not aligned to the stride unit, whose qid is `NUM_Q` or more, or that arrives while ready is 0.
- R10: Reads return data with `bus_rvalid` high in the cycle after the read request. Doorbell addresses and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| dev_fatal | input | 1 | Device-side fatal condition |
| dev_busy | input | 1 | Device-side processing indication |
| cfg_en | output | 1 | Configuration enable bit |
| ctrl_ready | output | 1 | Delayed ready status |
| asq_base | output | 64 | Admin submission ring base |
| acq_base | output | 64 | Admin completion ring base |
| db_strobe | output | 1 | Doorbell write pulse |
| db_qid | output | QID_W | Queue number of the doorbell |
| db_is_cq | output | 1 | 1 = completion-head doorbell |
| db_value | output | 32 | Value written to the doorbell |

## Verification
A wrong address decode shows up on the first write to the affected doorbell. The strobe appears with the wrong queue number or type, or fails to appear, in the cycle after the write. An off-by-one in the ready countdown shifts `ctrl_ready` by a single edge, so the bench samples it at every edge of the window rather than only at the end. A missing lock or mask lets a later write change a base or attribute value, and the next read-back exposes it.

// File: rtl/qctl_regfile.sv
module qctl_regfile #(
  parameter int NUM_Q   = 4,
  parameter int STRIDE  = 0,
  parameter int RDY_DLY = 4,
  parameter int QDEPTH  = 64,
  parameter logic [31:0] VERSION = 32'h0001_0400,
  localparam int QID_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int CW     = $clog2(RDY_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [12:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  input  logic             dev_fatal,
  input  logic             dev_busy,
  output logic             cfg_en,
  output logic             ctrl_ready,
  output logic [63:0]      asq_base,
  output logic [63:0]      acq_base,
  output logic             db_strobe,
  output logic [QID_W-1:0] db_qid,
  output logic             db_is_cq,
  output logic [31:0]      db_value
);
  localparam logic [31:0] CFG_MASK = 32'h00FF_0001;
  localparam logic [31:0] AQA_MASK = 32'h0FFF_0FFF;
  localparam logic [11:0] UNIT_LSB = 12'((4 << STRIDE) - 1);

  logic [31:0]   cfg_q, aqa_q, rd_mux;
  logic [CW-1:0] cnt_q;
  logic [11:0]   db_off, db_idx, db_q;
  logic          wr, rd, db_hit;

  assign wr     = bus_sel && bus_wr;
  assign rd     = bus_sel && !bus_wr;
  assign cfg_en = cfg_q[0];

  assign db_off = bus_addr[11:0];
  assign db_idx = db_off >> (STRIDE + 2);
  assign db_q   = db_idx >> 1;
  assign db_hit = bus_addr[12] && ((db_off & UNIT_LSB) == 12'd0)
                  && (db_q < 12'(NUM_Q)) && ctrl_ready;

  always_comb begin
    case (bus_addr)
      13'h000: rd_mux = {16'd0, 16'(QDEPTH - 1)};
      13'h004: rd_mux = {28'd0, 4'(STRIDE)};
      13'h008: rd_mux = VERSION;
      13'h014: rd_mux = cfg_q;
      13'h01C: rd_mux = {29'd0, dev_busy, dev_fatal, ctrl_ready};
      13'h024: rd_mux = aqa_q;
      13'h028: rd_mux = asq_base[31:0];
      13'h02C: rd_mux = asq_base[63:32];
      13'h030: rd_mux = acq_base[31:0];
      13'h034: rd_mux = acq_base[63:32];
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      aqa_q      <= '0;
      asq_base   <= '0;
      acq_base   <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      db_strobe  <= 1'b0;
      db_qid     <= '0;
      db_is_cq   <= 1'b0;
      db_value   <= '0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : 32'd0;
      db_strobe  <= wr && db_hit;
      if (wr && db_hit) begin
        db_qid   <= db_q[QID_W-1:0];
        db_is_cq <= db_idx[0];
        db_value <= bus_wdata;
      end
      if (wr) begin
        case (bus_addr)
          13'h014: cfg_q <= bus_wdata & CFG_MASK;
          13'h024: if (!cfg_en) aqa_q <= bus_wdata & AQA_MASK;
          13'h028: if (!cfg_en) asq_base[31:0]  <= bus_wdata;
          13'h02C: if (!cfg_en) asq_base[63:32] <= bus_wdata;
          13'h030: if (!cfg_en) acq_base[31:0]  <= bus_wdata;
          13'h034: if (!cfg_en) acq_base[63:32] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      ctrl_ready <= 1'b0;
    end else if (cfg_en == ctrl_ready) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(RDY_DLY - 1)) begin
      cnt_q      <= '0;
      ctrl_ready <= cfg_en;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_ready_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_ready) |-> $past(cfg_en));
  p_ready_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_ready) |-> !$past(cfg_en));
  p_base_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_en) |-> ($stable(asq_base) && $stable(acq_base) && $stable(aqa_q)));
  p_db_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    db_strobe |-> $past(bus_sel && bus_wr && bus_addr[12]));
  p_db_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    db_strobe |-> $past(ctrl_ready));
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_sel && !bus_wr));
endmodule

// File: tb/qctl_regfile_tb.sv
module qctl_regfile_tb;
  localparam int CLK_NS = 10;
  localparam int NQ  = 4;
  localparam int STR = 1;
  localparam int DLY = 3;
  localparam int QD  = 32;
  localparam logic [31:0] VER = 32'h0002_0100;
  localparam int UNIT = 4 << STR;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [12:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_rvalid, dev_fatal = 0, dev_busy = 0, cfg_en, ctrl_ready;
  logic [63:0] asq_base, acq_base;
  logic db_strobe, db_is_cq;
  logic [1:0] db_qid;
  logic [31:0] db_value;

  int errors = 0, checks = 0;
  logic done = 0;
  logic s_stb, s_cq;
  logic [1:0] s_qid;
  logic [31:0] s_val, rv;

  always #(CLK_NS/2) clk = ~clk;

  qctl_regfile #(.NUM_Q(NQ), .STRIDE(STR), .RDY_DLY(DLY), .QDEPTH(QD), .VERSION(VER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dev_fatal(dev_fatal), .dev_busy(dev_busy), .cfg_en(cfg_en), .ctrl_ready(ctrl_ready),
    .asq_base(asq_base), .acq_base(acq_base), .db_strobe(db_strobe), .db_qid(db_qid),
    .db_is_cq(db_is_cq), .db_value(db_value));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    s_stb = db_strobe; s_qid = db_qid; s_cq = db_is_cq; s_val = db_value;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [12:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    rv = bus_rdata;
    chk(req, {31'd0, bus_rvalid}, 64'd1);
    chk(req, {32'd0, rv}, {32'd0, exp});
    bus_sel = 0;
    @(negedge clk);
    chk("R10", {63'd0, bus_rvalid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {62'd0, cfg_en, ctrl_ready}, 64'd0);
    chk("R1", {63'd0, db_strobe}, 64'd0);
    rd(13'h014, "R1", 0);
    rd(13'h024, "R1", 0);
    rd(13'h028, "R1", 0);
    rd(13'h034, "R1", 0);

    rd(13'h000, "R2", QD - 1);
    rd(13'h004, "R2", STR);
    rd(13'h008, "R2", VER);
    wr(13'h000, 32'hFFFF_FFFF); wr(13'h004, 32'hFFFF_FFFF);
    wr(13'h008, 32'h0); wr(13'h01C, 32'hFFFF_FFFF);
    rd(13'h000, "R2", QD - 1);
    rd(13'h004, "R2", STR);
    rd(13'h008, "R2", VER);
    rd(13'h01C, "R2", 0);

    for (int f = 0; f < 4; f++) begin
      dev_fatal = f[0]; dev_busy = f[1];
      rd(13'h01C, "R5", {29'd0, f[1], f[0], 1'b0});
    end
    dev_fatal = 0; dev_busy = 0;

    rd(13'h010, "R10", 0);
    rd(13'h0FC, "R10", 0);
    rd(13'h00C, "R10", 0);

    wr(13'h024, 32'hFFFF_FFFF);
    rd(13'h024, "R6", 32'h0FFF_0FFF);
    wr(13'h028, 32'h1111_2000); wr(13'h02C, 32'h0000_00AB);
    wr(13'h030, 32'h3333_4000); wr(13'h034, 32'h0000_00CD);
    rd(13'h028, "R6", 32'h1111_2000);
    rd(13'h02C, "R6", 32'h0000_00AB);
    chk("R6", asq_base, 64'h0000_00AB_1111_2000);
    chk("R6", acq_base, 64'h0000_00CD_3333_4000);

    wr(13'h1000, 32'h55);
    chk("R9", {63'd0, s_stb}, 64'd0);

    wr(13'h014, 32'hFFFF_FFFF);
    rd(13'h014, "R3", 32'h00FF_0001);
    chk("R3", {63'd0, cfg_en}, 64'd1);
    wr(13'h014, 32'h0);
    for (int k = 1; k <= DLY + 1; k++) @(negedge clk);
    chk("R4", {63'd0, ctrl_ready}, 64'd0);

    wr(13'h014, 32'h1);
    for (int k = 1; k <= DLY + 1; k++) begin
      chk("R4", {63'd0, ctrl_ready}, {63'd0, k > DLY});
      @(negedge clk);
    end
    rd(13'h01C, "R4", 1);

    wr(13'h024, 0); wr(13'h028, 0); wr(13'h02C, 0); wr(13'h030, 0); wr(13'h034, 0);
    rd(13'h024, "R7", 32'h0FFF_0FFF);
    chk("R7", asq_base, 64'h0000_00AB_1111_2000);
    chk("R7", acq_base, 64'h0000_00CD_3333_4000);

    for (int q = 0; q <= NQ; q++) begin
      for (int t = 0; t < 2; t++) begin
        logic [12:0] a;
        logic [31:0] v;
        a = 13'(32'h1000 + (2 * q + t) * UNIT);
        v = 32'hA500_0000 + 32'(q * 16 + t);
        wr(a, v);
        if (q < NQ) begin
          chk("R8", {63'd0, s_stb}, 64'd1);
          chk("R8", {30'd0, s_qid, s_cq, v}, {30'd0, 2'(q), 1'(t), v});
          @(negedge clk);
          chk("R8", {63'd0, db_strobe}, 64'd0);
        end else begin
          chk("R9", {63'd0, s_stb}, 64'd0);
        end
        wr(a + 13'd4, v);
        chk("R9", {63'd0, s_stb}, 64'd0);
      end
    end
    rd(13'h1000, "R10", 0);

    wr(13'h014, 32'h0);
    for (int k = 1; k <= DLY + 1; k++) begin
      chk("R4", {63'd0, ctrl_ready}, {63'd0, k <= DLY});
      @(negedge clk);
    end
    wr(13'h1000 + 13'(UNIT), 32'h77);
    chk("R9", {63'd0, s_stb}, 64'd0);
    wr(13'h028, 32'h9999_0000);
    rd(13'h028, "R7", 32'h9999_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule